// File: doc/BRIEF.md
# Complex-Gain Table Trainer with Least-Mean-Squares Adaptation

This block trains a table of complex gains that linearises a power amplifier by indirect learning. Each incoming pair holds two samples. One is the amplifier output, already time-aligned and scaled to unity gain. The other is the sample that the predistorter produced at the same instant. The amplifier sample's squared envelope selects one table entry. The block then applies that entry's gain to the amplifier sample and measures how far the result falls from the desired sample. It moves the entry against the error by a step whose size is set at run time by a right-shift.

Once training has converged, a copy command streams the whole table out through a write port. The port takes a write strobe, an address and a complex gain, and it feeds the table of the live predistorter. A clear command restores every entry to unity gain. Adaptation stops while a copy or a clear is running.

All samples and gains are signed 16-bit values in Q2.14, so 16384 stands for 1.0.

Top module: `lms_table_trainer`

## Requirements
- R1: While reset is held and in the first cycle after it, in_ready is 1 and pd_we, copy_done and clear_done are 0.
- R2: An accepted pair addresses entry k = floor((amp_i^2 + amp_q^2) / 2^(28-AW)), where AW = log2(DEPTH). When amp_i^2 + amp_q^2 >= 2^28 (envelope at or above 1.0), k is DEPTH-1. Only entry k changes.
- R3: The entry G = (gi, gq) becomes G + (E * conj(Y)) >>> (14 + mu). Here Y = (amp_i, amp_q), D = (des_i, des_q) and E = D - ((G * Y) >>> 14). The complex product is formed per component: re = a.re*b.re - a.im*b.im, im = a.re*b.im + a.im*b.re. Every shift is an arithmetic (floor) shift of the full-precision value. mu is the mu_shift value sampled with the pair.
- R4: Each updated component saturates to the range -32768..32767 and never wraps.
- R5: A pair is accepted on a rising edge where in_valid and in_ready are both 1. in_ready is then 0 for the next three cycles and returns to 1 in the fourth, unless a command starts. This allows one pair every four cycles.
- R6: A clear_start pulse that is accepted sets every entry to (16384, 0). clear_done is high for exactly one cycle, DEPTH clock edges after the edge that sampled clear_start.
- R7: A copy_start pulse that is accepted writes the entries on DEPTH consecutive cycles. Each write has pd_we at 1, addresses run 0 to DEPTH-1 in ascending order, and each carries that entry's current gain on pd_gain_i and pd_gain_q. The first write comes one edge after the start edge. copy_done is high for one cycle, together with the final write.
- R8: A command is accepted only when the block is idle and no update is in flight. Otherwise the command is ignored. clear_start takes priority over copy_start, and either one takes priority over a pair offered in the same cycle. in_ready stays 0 while a command runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mu_shift | input | 4 | Step-size shift, sampled with each pair |
| in_valid | input | 1 | Pair offered |
| in_ready | output | 1 | Pair can be accepted this cycle |
| amp_i | input | DW | Amplifier output, real part |
| amp_q | input | DW | Amplifier output, imaginary part |
| des_i | input | DW | Desired sample, real part |
| des_q | input | DW | Desired sample, imaginary part |
| clear_start | input | 1 | Pulse: reset all entries to unity |
| clear_done | output | 1 | One-cycle end-of-clear pulse |
| copy_start | input | 1 | Pulse: stream table to predistorter |
| copy_done | output | 1 | One-cycle pulse with final copy write |
| pd_we | output | 1 | Predistorter table write strobe |
| pd_addr | output | AW | Predistorter table write address |
| pd_gain_i | output | DW | Gain written, real part |
| pd_gain_q | output | DW | Gain written, imaginary part |

## Verification
The table can only be seen at the ports through a copy. A corrupted entry, a wrong bin choice or a wrong update step therefore shows up in the next copy. It appears as a mismatched gain at one particular address, and that address points to the bin or the step that went wrong. A state machine that stays in a state too long or leaves it too early shows up sooner. The cycle after acceptance is the first place to see it: in_ready reopens at the wrong time, or a write strobe or done pulse arrives on the wrong edge. The bench runs a small table so that a sweep can visit every bin. It models the arithmetic independently and compares every entry after each copy.

// File: rtl/lms_table_trainer.sv
module lms_table_trainer #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  parameter int FRAC  = 14,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           mu_shift,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] amp_i,
  input  logic signed [DW-1:0] amp_q,
  input  logic signed [DW-1:0] des_i,
  input  logic signed [DW-1:0] des_q,
  input  logic                 clear_start,
  output logic                 clear_done,
  input  logic                 copy_start,
  output logic                 copy_done,
  output logic                 pd_we,
  output logic [AW-1:0]        pd_addr,
  output logic signed [DW-1:0] pd_gain_i,
  output logic signed [DW-1:0] pd_gain_q
);

  localparam int PW = 2*DW + 1;
  localparam int UW = PW + DW + 1;
  localparam logic [PW-1:0]        ENV_ONE = PW'(1) << (2*FRAC);
  localparam logic signed [DW-1:0] UNITY   = DW'(1) << FRAC;
  localparam logic signed [DW-1:0] GMAX    = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] GMIN    = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_RD, S_ERR, S_WR, S_CPY, S_CLR} state_t;
  state_t st;

  logic [2*DW-1:0] mem [DEPTH];
  logic [2*DW-1:0] rdat;
  logic [AW-1:0]   addr_r, cnt, raddr;
  logic signed [DW-1:0] y_i, y_q, d_i, d_q;
  logic [3:0]      mu_r;
  logic signed [PW-1:0] er_i, er_q;

  // envelope binning of the incoming amplifier sample
  logic signed [2*DW-1:0] sq_i, sq_q;
  logic [PW-1:0] env;
  logic [AW-1:0] env_idx;
  assign sq_i    = amp_i * amp_i;
  assign sq_q    = amp_q * amp_q;
  assign env     = {1'b0, sq_i} + {1'b0, sq_q};
  assign env_idx = (env >= ENV_ONE) ? AW'(DEPTH-1) : env[2*FRAC-1 -: AW];

  assign in_ready = (st == S_IDLE) && !clear_start && !copy_start;

  // stored gain of the addressed entry
  logic signed [DW-1:0] g_i, g_q;
  assign g_i = rdat[2*DW-1:DW];
  assign g_q = rdat[DW-1:0];

  // error: desired minus gained amplifier sample
  logic signed [PW-1:0] gy_i, gy_q, e_i, e_q;
  assign gy_i = PW'(g_i) * PW'(y_i) - PW'(g_q) * PW'(y_q);
  assign gy_q = PW'(g_i) * PW'(y_q) + PW'(g_q) * PW'(y_i);
  assign e_i  = PW'(d_i) - (gy_i >>> FRAC);
  assign e_q  = PW'(d_q) - (gy_q >>> FRAC);

  // step: error times conjugate of amplifier sample
  logic signed [UW-1:0] u_i, u_q, n_i, n_q;
  assign u_i = UW'(er_i) * UW'(y_i) + UW'(er_q) * UW'(y_q);
  assign u_q = UW'(er_q) * UW'(y_i) - UW'(er_i) * UW'(y_q);
  assign n_i = UW'(g_i) + (u_i >>> (FRAC + int'(mu_r)));
  assign n_q = UW'(g_q) + (u_q >>> (FRAC + int'(mu_r)));

  function automatic logic signed [DW-1:0] clip(input logic signed [UW-1:0] v);
    if (v > UW'(GMAX)) return GMAX;
    if (v < UW'(GMIN)) return GMIN;
    return v[DW-1:0];
  endfunction

  logic signed [DW-1:0] w_i, w_q;
  assign w_i = clip(n_i);
  assign w_q = clip(n_q);

  assign raddr = (st == S_CPY) ? cnt : addr_r;

  always_ff @(posedge clk) begin
    rdat <= mem[raddr];
    if (st == S_WR)
      mem[addr_r] <= {w_i, w_q};
    else if (st == S_CLR)
      mem[cnt] <= {UNITY, {DW{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      addr_r     <= '0;
      y_i        <= '0;
      y_q        <= '0;
      d_i        <= '0;
      d_q        <= '0;
      mu_r       <= '0;
      er_i       <= '0;
      er_q       <= '0;
      pd_we      <= 1'b0;
      pd_addr    <= '0;
      copy_done  <= 1'b0;
      clear_done <= 1'b0;
    end else begin
      pd_we      <= (st == S_CPY);
      pd_addr    <= cnt;
      copy_done  <= (st == S_CPY) && (cnt == AW'(DEPTH-1));
      clear_done <= (st == S_CLR) && (cnt == AW'(DEPTH-1));
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (clear_start)      st <= S_CLR;
          else if (copy_start)  st <= S_CPY;
          else if (in_valid) begin
            st     <= S_RD;
            addr_r <= env_idx;
            y_i    <= amp_i;
            y_q    <= amp_q;
            d_i    <= des_i;
            d_q    <= des_q;
            mu_r   <= mu_shift;
          end
        end
        S_RD:  st <= S_ERR;
        S_ERR: begin
          er_i <= e_i;
          er_q <= e_q;
          st   <= S_WR;
        end
        S_WR:  st <= S_IDLE;
        S_CPY, S_CLR: begin
          cnt <= cnt + 1'b1;
          if (cnt == AW'(DEPTH-1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pd_gain_i = rdat[2*DW-1:DW];
  assign pd_gain_q = rdat[DW-1:0];

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready ##1 !in_ready ##1 !in_ready);

  assert_copy_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_we && $past(pd_we)) |-> (pd_addr == $past(pd_addr) + 1'b1));

  assert_copy_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> (pd_we && pd_addr == AW'(DEPTH-1)));

  assert_clear_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_done |=> !clear_done);

  assert_paused_in_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_we && !copy_done) |-> !in_ready);

endmodule

// File: tb/test_lms_table_trainer.sv
module test_lms_table_trainer;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [3:0] mu_shift = 0;
  logic in_valid = 0, in_ready;
  logic signed [15:0] amp_i = 0, amp_q = 0, des_i = 0, des_q = 0;
  logic clear_start = 0, clear_done, copy_start = 0, copy_done, pd_we;
  logic [AW-1:0] pd_addr;
  logic signed [15:0] pd_gain_i, pd_gain_q;

  lms_table_trainer #(.DEPTH(DEPTH)) i_lms_table_trainer (
    .clk(clk), .rst_n(rst_n), .mu_shift(mu_shift), .in_valid(in_valid), .in_ready(in_ready),
    .amp_i(amp_i), .amp_q(amp_q), .des_i(des_i), .des_q(des_q),
    .clear_start(clear_start), .clear_done(clear_done),
    .copy_start(copy_start), .copy_done(copy_done),
    .pd_we(pd_we), .pd_addr(pd_addr), .pd_gain_i(pd_gain_i), .pd_gain_q(pd_gain_q));

  always #10 clk = ~clk;

  int total = 0, fails = 0, cycles = 0;
  longint mg_i [DEPTH];
  longint mg_q [DEPTH];
  longint cp_i [DEPTH];
  longint cp_q [DEPTH];

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic int bin_of(longint yi, longint yq);
    longint m = yi*yi + yq*yq;
    if (m >= (longint'(1) << 28)) return DEPTH-1;
    return int'(m >> (28 - AW));
  endfunction

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint isqrt(longint m);
    longint r = 0;
    while ((r+1)*(r+1) <= m) r++;
    return r;
  endfunction

  task automatic model(longint yi, longint yq, longint di, longint dq, int mu);
    int k = bin_of(yi, yq);
    longint gi = mg_i[k], gq = mg_q[k];
    longint ei = di - ((gi*yi - gq*yq) >>> 14);
    longint eq = dq - ((gi*yq + gq*yi) >>> 14);
    longint ui = ei*yi + eq*yq;
    longint uq = eq*yi - ei*yq;
    mg_i[k] = sat(gi + (ui >>> (14 + mu)));
    mg_q[k] = sat(gq + (uq >>> (14 + mu)));
  endtask

  task automatic send(int yi, int yq, int di, int dq, int mu);
    while (!in_ready) @(negedge clk);
    amp_i = 16'(yi); amp_q = 16'(yq); des_i = 16'(di); des_q = 16'(dq);
    mu_shift = 4'(mu); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    model(yi, yq, di, dq, mu);
    for (int c = 1; c <= 3; c++) begin
      if (c > 1) @(negedge clk);
      chk("R5", "in_ready low while busy", in_ready, 0);
    end
    @(negedge clk);
    chk("R5", "in_ready back after window", in_ready, 1);
  endtask

  task automatic do_clear();
    int c = 0;
    @(negedge clk); clear_start = 1;
    @(negedge clk); clear_start = 0;
    chk("R8", "in_ready low during clear", in_ready, 0);
    while (!clear_done && c < 4*DEPTH) begin @(negedge clk); c++; end
    chk("R6", "clear_done delay", c, DEPTH);
    @(negedge clk);
    chk("R6", "clear_done single cycle", clear_done, 0);
    for (int k = 0; k < DEPTH; k++) begin mg_i[k] = 16384; mg_q[k] = 0; end
  endtask

  task automatic do_copy(string req);
    @(negedge clk); copy_start = 1;
    @(negedge clk); copy_start = 0;
    for (int n = 1; n <= DEPTH; n++) begin
      @(negedge clk);
      chk("R7", "pd_we during copy", pd_we, 1);
      chk("R7", "pd_addr order", pd_addr, n-1);
      chk("R7", "copy_done timing", copy_done, (n == DEPTH) ? 1 : 0);
      if (n < DEPTH) chk("R8", "in_ready low during copy", in_ready, 0);
      cp_i[n-1] = pd_gain_i; cp_q[n-1] = pd_gain_q;
    end
    @(negedge clk);
    chk("R7", "pd_we drops after copy", pd_we, 0);
    for (int k = 0; k < DEPTH; k++) begin
      chk(req, $sformatf("entry %0d real", k), cp_i[k], mg_i[k]);
      chk(req, $sformatf("entry %0d imag", k), cp_q[k], mg_q[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", in_ready, 1);
    chk("R1", "pd_we in reset", pd_we, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "copy_done after reset", copy_done, 0);
    chk("R1", "clear_done after reset", clear_done, 0);
    chk("R1", "pd_we after reset", pd_we, 0);

    do_clear();
    do_copy("R6");

    // R2/R3: one pair aimed at the centre of every bin, various steps
    for (int k = 0; k < DEPTH; k++) begin
      int y = int'(isqrt(longint'(k) * (1 << 24) + (1 << 23)));
      send(y, 0, 9000 - 700*k, 3000 + 211*k, k % 5);
    end
    do_copy("R2");
    for (int k = 0; k < DEPTH; k++) begin
      int y = int'(isqrt(longint'(k) * (1 << 24) + (1 << 23)));
      send(-y/2, y - y/3, -4000 + 500*k, 12000 - 300*k, (k + 2) % 7);
    end
    do_copy("R3");

    // R3: broad pseudo-random pairs, envelopes above 1.0 included
    for (int r = 0; r < 150; r++) begin
      int yi = int'($urandom_range(0, 50000)) - 25000;
      int yq = int'($urandom_range(0, 50000)) - 25000;
      int di = int'($urandom_range(0, 65535)) - 32768;
      int dq = int'($urandom_range(0, 65535)) - 32768;
      send(yi, yq, di, dq, int'($urandom_range(0, 10)));
    end
    do_copy("R3");

    // R4: drive entries into both rails
    do_clear();
    for (int r = 0; r < 6; r++) send(8192, 0, 32767, 0, 0);
    for (int r = 0; r < 6; r++) send(12000, 0, -32768, 0, 0);
    do_copy("R4");
    chk("R4", "positive rail entry 4", cp_i[4], 32767);
    chk("R4", "negative rail entry 8", cp_i[8], -32768);
    chk("R2", "untouched entry 5", cp_i[5], 16384);

    // R2: envelope at exactly 1.0 lands in last entry
    send(16384, 0, 0, 20000, 1);
    send(0, -20000, 5000, 0, 2);
    do_copy("R2");

    // R8: copy_start while an update is in flight is ignored
    begin
      int seen = 0;
      while (!in_ready) @(negedge clk);
      amp_i = 16'(3000); amp_q = 16'(1000); des_i = 16'(-2000); des_q = 16'(7000);
      mu_shift = 4'(3); in_valid = 1;
      @(negedge clk); in_valid = 0; copy_start = 1;
      model(3000, 1000, -2000, 7000, 3);
      @(negedge clk); copy_start = 0;
      for (int c = 0; c < DEPTH + 6; c++) begin @(negedge clk); if (pd_we) seen++; end
      chk("R8", "copy_start during update ignored", seen, 0);
    end
    do_copy("R8");

    // R8: clear wins over copy and over a pair offered together
    begin
      int seen = 0, c = 0;
      @(negedge clk);
      clear_start = 1; copy_start = 1; in_valid = 1;
      amp_i = 16'(4000); amp_q = 0; des_i = 16'(100); des_q = 0;
      #1 chk("R8", "in_ready low with command", in_ready, 0);
      @(negedge clk); clear_start = 0; copy_start = 0; in_valid = 0;
      while (!clear_done && c < 4*DEPTH) begin @(negedge clk); c++; if (pd_we) seen++; end
      chk("R8", "clear chosen over copy", c, DEPTH);
      chk("R8", "no copy writes", seen, 0);
      for (int k = 0; k < DEPTH; k++) begin mg_i[k] = 16384; mg_q[k] = 0; end
    end
    do_copy("R8");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule